// File: doc/BRIEF.md
# UART Receive/Transmit FIFO and Interrupt Controller

This block sits between a processor's register port and the serial shifters of a 16550-style UART. It holds one byte queue for received characters and one for characters waiting to be sent. It holds the control and enable settings that govern both queues, and it combines the pending event sources into one interrupt line. The receive shifter pushes bytes in, and the processor pops them out. The processor pushes bytes for transmission, and the transmit shifter pops them.

Software sets up the block with byte writes to two registers. The queue-control register turns the queues on or off, empties either queue, and picks the receive fill threshold. The interrupt-enable register masks each source. Software learns what happened from byte reads of two registers. The identification register gives an encoded source code. The line-status register gives receive-ready, overrun and transmit-room flags. Baud timing and serial shifting happen outside this block.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset both queues are empty, all interrupt enables are clear and `irq` is low. The identification register reads 0x01 and line status reads 0x20.
- R2: Queue-control bit 0 turns the queues on. When on, each queue holds DEPTH (16) bytes. When off, each holds one byte. A write that changes bit 0 empties both queues.
- R3: In a queue-control write, bit 1 empties the receive queue and bit 2 empties the transmit queue, each by the next cycle. These bits are one-shot strobes and are not stored, so bytes pushed afterwards are kept.
- R4: Queue-control bits 7:6 pick the receive threshold: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. The receive-data source is pending while the receive count is at or above this threshold. When the queues are off, the threshold is 1.
- R5: In the interrupt-enable register, bit 0 masks receive data, bit 1 masks transmit empty and bit 2 masks line status. A masked source never raises `irq` and never shows in the identification register.
- R6: The identification register places the source code in bits 3:1 and a no-pending flag in bit 0. Bit 0 is 0 while any enabled source is pending and 1 otherwise. Bits 7:6 both equal queue-control bit 0. `irq` is the inverse of bit 0.
- R7: Only one source code is reported at a time. Line status (code 3) wins over receive data (code 2), which wins over transmit empty (code 1). Code 0 means nothing is pending.
- R8: Line-status bit 0 is 1 while the receive queue holds a byte. Bit 5 is 1 while the transmit queue can take another byte.
- R9: A push into a full receive queue drops the byte and sets line-status bit 1, the overrun flag. The overrun flag is the line-status source. A line-status read clears it in the following cycle.
- R10: The transmit-empty source becomes pending in any of three ways: a pop empties the transmit queue, the transmit queue is emptied by control, or enable bit 1 rises while the queue is empty. It is cleared by a push into the transmit queue, or by an identification read that returns code 1. After such a read it stays clear until the queue empties again.
- R11: Both queues give bytes out in the order they were pushed. A pop from an empty queue changes nothing. A push into a full transmit queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 queue control, 1 interrupt enable |
| reg_wr_data | input | 8 | Write data |
| reg_rd_en | input | 1 | Register read strobe (starts read side effects) |
| reg_rd_sel | input | 1 | Read source: 0 identification, 1 line status |
| reg_rd_data | output | 8 | Read data for the selected register |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Processor takes the oldest received byte |
| rx_pop_data | output | 8 | Oldest received byte |
| tx_push | input | 1 | Processor queues a byte for sending |
| tx_push_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Transmit shifter takes the oldest byte |
| tx_pop_data | output | 8 | Oldest byte waiting to be sent |
| tx_pending | output | 1 | Transmit queue holds at least one byte |
| irq | output | 1 | Interrupt request, high while an enabled source is pending |

## Verification
A wrong receive count shows at `irq` and in the identification code in the first cycle after the push that crosses the selected threshold. The sweep over all four thresholds and every fill level catches this. A corrupted pointer or storage slot shows as the wrong byte at the next pop, and the full-queue drains compare every byte. A transmit-empty latch that is stuck or cleared at the wrong time shows at `irq` one cycle after the pop, push or identification read that should have changed it.

// File: rtl/ufi_pkg.sv
package ufi_pkg;

  typedef enum logic [2:0] {
    SRC_NONE     = 3'd0,
    SRC_TX_EMPTY = 3'd1,
    SRC_RX_DATA  = 3'd2,
    SRC_LINE     = 3'd3
  } src_code_e;

  // bit positions software relies on
  localparam int CTL_QUEUE_ON = 0;
  localparam int CTL_RX_FLUSH = 1;
  localparam int CTL_TX_FLUSH = 2;
  localparam int CTL_TRIG_LO  = 6;
  localparam int IE_RX_DATA   = 0;
  localparam int IE_TX_EMPTY  = 1;
  localparam int IE_LINE      = 2;

  // receive threshold in bytes for a selector, clipped to the queue depth
  function automatic int unsigned trig_threshold(logic queue_on, logic [1:0] sel,
                                                 int unsigned depth);
    int unsigned t;
    if (!queue_on) return 1;
    case (sel)
      2'd0:    t = 1;
      2'd1:    t = 4;
      2'd2:    t = 8;
      default: t = 14;
    endcase
    if (t > depth) t = depth;
    return t;
  endfunction

  function automatic logic [7:0] ident_byte(logic queue_on, src_code_e code);
    return {queue_on, queue_on, 2'b00, code, (code == SRC_NONE)};
  endfunction

  function automatic logic [7:0] status_byte(logic rx_ready, logic overrun, logic tx_room);
    return {2'b00, tx_room, 3'b000, overrun, rx_ready};
  endfunction

endpackage

// File: rtl/ufi_byte_fifo.sv
module ufi_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             single,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] step(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = single ? !empty : (count == CW'(DEPTH));
  assign push_ok = push && !clr && !full;
  assign pop_ok  = pop && !clr && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/ufi_ctrl_regs.sv
module ufi_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       queue_on,
  output logic [1:0] trig_sel,
  output logic [2:0] ie,
  output logic       rx_flush,
  output logic       tx_flush,
  output logic       tx_ie_rise
);
  import ufi_pkg::*;

  logic wr_ctl, wr_ie, mode_flip;

  assign wr_ctl    = wr_en && !wr_sel;
  assign wr_ie     = wr_en && wr_sel;
  assign mode_flip = wr_ctl && (wr_data[CTL_QUEUE_ON] != queue_on);
  assign rx_flush  = (wr_ctl && wr_data[CTL_RX_FLUSH]) || mode_flip;
  assign tx_flush  = (wr_ctl && wr_data[CTL_TX_FLUSH]) || mode_flip;
  assign tx_ie_rise = wr_ie && wr_data[IE_TX_EMPTY] && !ie[IE_TX_EMPTY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      queue_on <= 1'b0;
      trig_sel <= 2'd0;
      ie       <= 3'd0;
    end else begin
      if (wr_ctl) begin
        queue_on <= wr_data[CTL_QUEUE_ON];
        trig_sel <= wr_data[CTL_TRIG_LO +: 2];
      end
      if (wr_ie) ie <= wr_data[2:0];
    end
  end

endmodule

// File: rtl/ufi_irq_prio.sv
module ufi_irq_prio (
  input  logic                 line_pend,
  input  logic                 rx_pend,
  input  logic                 tx_pend,
  output ufi_pkg::src_code_e   code
);
  import ufi_pkg::*;

  always_comb begin
    if (line_pend)    code = SRC_LINE;
    else if (rx_pend) code = SRC_RX_DATA;
    else if (tx_pend) code = SRC_TX_EMPTY;
    else              code = SRC_NONE;
  end

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic       reg_wr_sel,
  input  logic [7:0] reg_wr_data,
  input  logic       reg_rd_en,
  input  logic       reg_rd_sel,
  output logic [7:0] reg_rd_data,
  input  logic       rx_push,
  input  logic [7:0] rx_push_data,
  input  logic       rx_pop,
  output logic [7:0] rx_pop_data,
  input  logic       tx_push,
  input  logic [7:0] tx_push_data,
  input  logic       tx_pop,
  output logic [7:0] tx_pop_data,
  output logic       tx_pending,
  output logic       irq
);
  import ufi_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  // configuration
  logic       queue_on, rx_flush, tx_flush, tx_ie_rise;
  logic [1:0] trig_sel;
  logic [2:0] ie;

  // queue state
  logic [CW-1:0] rx_count, tx_count, rx_level;
  logic rx_empty, rx_full, rx_push_ok, rx_pop_ok;
  logic tx_empty, tx_full, tx_push_ok, tx_pop_ok;

  // named internal events
  logic overrun, thre_pend;
  logic overrun_set, lsr_rd, id_rd, id_rd_txe;
  logic tx_drained, thre_set, thre_clr;
  logic rx_at_level, line_pend, rx_pend, tx_pend;
  src_code_e code;
  logic [7:0] ident, status;

  ufi_ctrl_regs u_regs (
    .clk, .rst_n,
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .queue_on, .trig_sel, .ie,
    .rx_flush, .tx_flush, .tx_ie_rise
  );

  ufi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk, .rst_n, .clr(rx_flush), .single(!queue_on),
    .push(rx_push), .pop(rx_pop), .din(rx_push_data), .dout(rx_pop_data),
    .count(rx_count), .empty(rx_empty), .full(rx_full),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  ufi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk, .rst_n, .clr(tx_flush), .single(!queue_on),
    .push(tx_push), .pop(tx_pop), .din(tx_push_data), .dout(tx_pop_data),
    .count(tx_count), .empty(tx_empty), .full(tx_full),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  // register reads and their side effects
  assign id_rd     = reg_rd_en && !reg_rd_sel;
  assign lsr_rd    = reg_rd_en && reg_rd_sel;
  assign id_rd_txe = id_rd && (code == SRC_TX_EMPTY);

  // overrun flag: a set in the same cycle as a read wins
  assign overrun_set = rx_push && !rx_push_ok && !rx_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           overrun <= 1'b0;
    else if (overrun_set) overrun <= 1'b1;
    else if (lsr_rd)      overrun <= 1'b0;
  end

  // transmit-empty latch
  assign tx_drained = tx_pop_ok && !tx_push_ok && (tx_count == CW'(1));
  assign thre_set   = tx_flush || tx_drained || (tx_ie_rise && tx_empty && !tx_push_ok);
  assign thre_clr   = tx_push_ok || id_rd_txe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thre_pend <= 1'b1;
    else if (thre_set) thre_pend <= 1'b1;
    else if (thre_clr) thre_pend <= 1'b0;
  end

  // pending sources
  assign rx_level    = CW'(trig_threshold(queue_on, trig_sel, DEPTH));
  assign rx_at_level = (rx_count >= rx_level);
  assign line_pend   = ie[IE_LINE] && overrun;
  assign rx_pend     = ie[IE_RX_DATA] && rx_at_level;
  assign tx_pend     = ie[IE_TX_EMPTY] && thre_pend;

  ufi_irq_prio u_prio (
    .line_pend, .rx_pend, .tx_pend, .code
  );

  assign ident       = ident_byte(queue_on, code);
  assign status      = status_byte(!rx_empty, overrun, !tx_full);
  assign reg_rd_data = reg_rd_sel ? status : ident;
  assign irq         = !ident[0];
  assign tx_pending  = !tx_empty;

endmodule

// File: rtl/ufi_chk.sv
module ufi_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          queue_on,
  input logic          rx_push,
  input logic          rx_full,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          overrun,
  input logic          line_pend,
  input logic          rx_pend,
  input logic [2:0]    code,
  input logic          irq,
  input logic          id_rd,
  input logic          thre_pend
);

  p_depth_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH) && tx_count <= CW'(DEPTH));

  p_single_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_on |-> (rx_count <= CW'(1) && tx_count <= CW'(1)));

  p_rx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_count == '0);

  p_tx_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_count == '0);

  p_irq_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != 3'd0));

  p_line_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_pend |-> code == 3'd3);

  p_rx_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_pend && rx_pend) |-> code == 3'd2);

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_push && rx_full && !rx_flush));

  p_txe_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && code == 3'd1 && !tx_flush) |=> !thre_pend);

endmodule

bind uart_fifo_irq ufi_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .queue_on(queue_on),
  .rx_push(rx_push), .rx_full(rx_full), .rx_flush(rx_flush), .tx_flush(tx_flush),
  .rx_count(rx_count), .tx_count(tx_count), .overrun(overrun),
  .line_pend(line_pend), .rx_pend(rx_pend), .code(code), .irq(irq),
  .id_rd(id_rd), .thre_pend(thre_pend)
);

// File: tb/sim_uart_fifo_irq.sv
module sim_uart_fifo_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 0, reg_wr_sel = 0, reg_rd_en = 0, reg_rd_sel = 0;
  logic [7:0] reg_wr_data = 0, reg_rd_data;
  logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_push_data = 0, tx_push_data = 0, rx_pop_data, tx_pop_data;
  logic       tx_pending, irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_fifo_irq #(.DEPTH(16)) u0 (
    .clk, .rst_n, .reg_wr_en, .reg_wr_sel, .reg_wr_data,
    .reg_rd_en, .reg_rd_sel, .reg_rd_data,
    .rx_push, .rx_push_data, .rx_pop, .rx_pop_data,
    .tx_push, .tx_push_data, .tx_pop, .tx_pop_data, .tx_pending, .irq
  );

  // bench-side rules
  function automatic int lvl(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
  endfunction
  function automatic logic [7:0] idv(bit on, int code);
    return (on ? 8'hC0 : 8'h00) | 8'(code << 1) | ((code == 0) ? 8'h01 : 8'h00);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wreg(bit sel, logic [7:0] d);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    tick();
    reg_wr_en = 0;
  endtask

  task automatic rreg(bit sel, output logic [7:0] d);
    reg_rd_en = 1; reg_rd_sel = sel;
    #1 d = reg_rd_data;
    tick();
    reg_rd_en = 0;
  endtask

  // peek without side effects
  task automatic peek(bit sel, output logic [7:0] d);
    reg_rd_sel = sel;
    #1 d = reg_rd_data;
  endtask

  task automatic rxp(logic [7:0] b);
    rx_push = 1; rx_push_data = b; tick(); rx_push = 0;
  endtask
  task automatic rxq(output logic [7:0] b);
    rx_pop = 1; #1 b = rx_pop_data; tick(); rx_pop = 0;
  endtask
  task automatic txp(logic [7:0] b);
    tx_push = 1; tx_push_data = b; tick(); tx_push = 0;
  endtask
  task automatic txq(output logic [7:0] b);
    tx_pop = 1; #1 b = tx_pop_data; tick(); tx_pop = 0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 irq", irq, 0);
    peek(0, d); chk("R1 ident", d, 8'h01);
    peek(1, d); chk("R1 lsr", d, 8'h20);
    chk("R1 tx_pending", tx_pending, 0);

    // R6 enable queues: bits 7:6 follow
    wreg(0, 8'h01);
    peek(0, d); chk("R6 ident mirror", d, idv(1, 0));
    wreg(1, 8'h01);

    // R4/R9/R7/R11 sweep over each threshold and every fill level
    for (int sel = 0; sel < 4; sel++) begin
      wreg(0, 8'(sel << 6) | 8'h03);
      wreg(1, 8'h01);
      for (int n = 1; n <= 16; n++) begin
        rxp(8'(sel * 16 + n));
        chk("R4 irq at fill", irq, (n >= lvl(sel)));
        peek(0, d); chk("R4 ident at fill", d, idv(1, (n >= lvl(sel)) ? 2 : 0));
      end
      peek(1, d); chk("R8 lsr full rx", d, 8'h21);
      rxp(8'hEE);
      peek(0, d); chk("R5 line masked", d, idv(1, 2));
      wreg(1, 8'h05);
      peek(0, d); chk("R7 line over rx", d, idv(1, 3));
      rreg(1, d); chk("R9 overrun flag", d, 8'h23);
      peek(1, d); chk("R9 overrun cleared", d, 8'h21);
      peek(0, d); chk("R9 back to rx code", d, idv(1, 2));
      for (int k = 1; k <= 16; k++) begin
        rxq(d); chk("R11 rx order", d, 8'(sel * 16 + k));
        chk("R4 irq on drain", irq, ((16 - k) >= lvl(sel)));
      end
      rxq(d);
      peek(1, d); chk("R11 pop empty ignored", d, 8'h20);
    end

    // R3 strobes are one-shot
    rxp(8'h31); rxp(8'h32); rxp(8'h33);
    wreg(0, 8'h03);
    peek(1, d); chk("R3 rx flushed", d, 8'h20);
    rxp(8'h41); rxp(8'h42); tick(); tick();
    rxq(d); chk("R3 later push kept", d, 8'h41);
    rxq(d); chk("R3 later push kept 2", d, 8'h42);
    for (int i = 0; i < 5; i++) txp(8'(i));
    chk("R3 tx loaded", tx_pending, 1);
    wreg(0, 8'h05);
    chk("R3 tx flushed", tx_pending, 0);

    // R10 transmit empty source
    wreg(1, 8'h02);
    chk("R10 pending after flush", irq, 1);
    rreg(0, d); chk("R10 ident code 1", d, idv(1, 1));
    chk("R10 read clears", irq, 0);
    peek(0, d); chk("R10 ident none", d, idv(1, 0));
    txp(8'hA1); txp(8'hB2);
    chk("R10 not pending with data", irq, 0);
    txq(d); chk("R11 tx order 1", d, 8'hA1);
    chk("R10 still data", irq, 0);
    txq(d); chk("R11 tx order 2", d, 8'hB2);
    chk("R10 drained raises", irq, 1);
    txp(8'hC3);
    chk("R10 push clears", irq, 0);
    txq(d);
    chk("R10 drained again", irq, 1);
    rreg(0, d);
    for (int i = 0; i < 16; i++) txp(8'(8'h80 + i));
    peek(1, d); chk("R8 tx full no room", d, 8'h00);
    txp(8'hFF);
    for (int i = 0; i < 16; i++) begin
      txq(d); chk("R11 tx full order", d, 8'(8'h80 + i));
    end
    chk("R11 full push dropped", tx_pending, 0);
    chk("R10 irq after drain", irq, 1);
    rreg(0, d);
    wreg(1, 8'h00);
    wreg(1, 8'h02);
    chk("R10 enable rise", irq, 1);
    peek(0, d); chk("R10 enable rise code", d, idv(1, 1));

    // R5 masked sources
    wreg(1, 8'h00);
    for (int i = 0; i < 17; i++) rxp(8'(i));
    chk("R5 all masked irq", irq, 0);
    peek(0, d); chk("R5 all masked ident", d, idv(1, 0));
    wreg(1, 8'h04);
    peek(0, d); chk("R5 line only", d, idv(1, 3));
    rreg(1, d);
    chk("R5 line cleared", irq, 0);
    wreg(1, 8'h00);

    // R2 queues off: one byte each, mode change flushes
    wreg(0, 8'h00);
    peek(0, d); chk("R6 ident off", d, 8'h01);
    peek(1, d); chk("R2 flush on mode change", d, 8'h20);
    rxp(8'hA5);
    peek(1, d); chk("R8 rx ready single", d, 8'h21);
    rxp(8'h5A);
    rreg(1, d); chk("R2 single overrun", d, 8'h23);
    rxq(d); chk("R2 single keeps first", d, 8'hA5);
    peek(1, d); chk("R2 single empty", d, 8'h20);
    txp(8'h11);
    peek(1, d); chk("R8 single tx no room", d, 8'h00);
    txp(8'h22);
    txq(d); chk("R2 single tx first", d, 8'h11);
    peek(1, d); chk("R8 single tx room", d, 8'h20);
    chk("R2 single second dropped", tx_pending, 0);
    wreg(0, 8'hC0);
    wreg(1, 8'h01);
    rxp(8'h33);
    chk("R4 off threshold one", irq, 1);
    peek(0, d); chk("R6 ident off rx", d, 8'h04);

    summary();
    $finish;
  end

endmodule